// File: doc/BRIEF.md
# Brown-out Reset Sequencer

This controller turns a digital "supply is under threshold" flag from an analog comparator into a held device reset. The comparator flag is first synchronised, then debounced by a cycle filter. A two-bit static policy field decides when detection is armed. An optional power-up delay holds reset for a fixed number of cycles after the supply recovers, and starts that delay over if the supply sags again while it is running.

Software reaches three status bits through a small write port: an arm bit that counts only under the software-gated policy, a power-on marker, and a brown-out marker. A brown-out event clears the brown-out marker. The power-on marker changes only on power-on reset or on a write. Software therefore tells a brown-out apart from a power-on by reading the brown-out marker as 0 while the power-on marker is still 1. The threshold select code is not used by the controller. It passes straight through to the analog side.

Top module: `brownout_seq`

## Requirements
- R1: With policy code 2'b00 detection is never armed, and no supply level leads to reset.
- R2: With policy code 2'b11 detection is always armed, whatever the sleep and arm-bit inputs are.
- R3: With policy code 2'b01 detection is armed only while the software arm bit (write data bit 2) is 1. Status bit 2 reads that arm bit under code 2'b01 and reads 0 under every other code.
- R4: With policy code 2'b10 detection is armed except while the sleep input is 1. Once sleep returns to 0, a low supply is detected again.
- R5: The supply flag passes through a two-stage synchroniser. The flag must then be seen high for FILT_CYCLES consecutive cycles before reset asserts. A raw low pulse that the synchroniser sees for FILT_CYCLES-1 cycles or fewer causes no reset. A flag that is raised and held raises rst_out exactly FILT_CYCLES+3 rising edges after it was driven.
- R6: Reset stays asserted for as long as the synchronised supply flag remains high.
- R7: With the delay disabled, rst_out falls on the third rising edge after the supply flag drops. Arming detection has no effect on whether the delay runs.
- R8: With the delay enabled, rst_out falls PWRT_CYCLES+3 rising edges after the supply flag drops.
- R9: If the supply flag rises while the delay is running, the controller returns to brown-out reset and clears the delay. After the flag next drops, the full delay runs again.
- R10: Each entry into brown-out reset clears the brown-out marker (status bit 0). A write can set the marker.
- R11: The power-on marker (status bit 1) is changed only by a write or by power-on reset.
- R12: vsel_out always equals cfg_vsel.
- R13: While por is 1, rst_out is 1. Power-on reset asynchronously clears all three status bits and all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| sup_low | input | 1 | Comparator flag, 1 when the supply is under threshold |
| cfg_mode | input | 2 | Static detection policy |
| cfg_pwrt_en | input | 1 | Static power-up delay enable |
| cfg_vsel | input | VSEL_W | Static threshold select code |
| sleep | input | 1 | 1 while the device is in Sleep |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 3 | Write data: bit 2 arm bit, bit 1 power-on marker, bit 0 brown-out marker |
| rst_out | output | 1 | Held device reset |
| stat | output | 3 | Status readback, same bit layout as wr_data |
| vsel_out | output | VSEL_W | Threshold select code to the comparator |

## Verification
The hardest state to reach is a supply sag that arrives while the power-up delay is partway through its count. Only that case shows whether the delay counter really starts over. The stimulus first trips a brown-out with the delay enabled. It then lets the supply recover, waits about half the delay, and raises the flag again. Finally it times the second release and expects the full delay, not the remaining half. The sleep-gated policy is also tricky. There the supply is held low across the wake-up, so the filter must start from zero at the moment detection re-arms.

// File: rtl/bor_seq_pkg.sv
package bor_seq_pkg;
   typedef enum logic [1:0] {
      MODE_OFF     = 2'b00,
      MODE_SW      = 2'b01,
      MODE_NOSLEEP = 2'b10,
      MODE_ON      = 2'b11
   } bor_mode_e;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_HOLD  = 2'd1,
      ST_DELAY = 2'd2
   } bor_state_e;

   localparam int STAT_W    = 3;
   localparam int STAT_ARM  = 2;
   localparam int STAT_PORM = 1;
   localparam int STAT_BORM = 0;
endpackage

// File: rtl/bor_sync.sv
module bor_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("bor_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or posedge por)
               if (por) chain[0] <= 1'b0;
               else     chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or posedge por)
               if (por) chain[i] <= 1'b0;
               else     chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bor_filter.sv
module bor_filter #(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic por,
   input  logic en,
   input  logic low,
   output logic trip
);
   localparam int CNT_W = $clog2(CYCLES + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYCLES);

   logic [CNT_W-1:0] cnt;

   generate
      if (CYCLES < 1) begin : g_bad
         $error("bor_filter: CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or posedge por) begin
      if (por)               cnt <= '0;
      else if (!(en && low)) cnt <= '0;
      else if (cnt != LIMIT) cnt <= cnt + CNT_W'(1);
   end

   assign trip = (cnt == LIMIT);

   // R5: a trip is only reached after an unbroken armed low run
   a_r5_trip_needs_run: assert property (@(posedge clk) disable iff (por)
      (trip && !$past(trip)) |-> $past(en && low));
endmodule

// File: rtl/bor_delay_timer.sv
module bor_delay_timer #(
   parameter int CYCLES = 64
) (
   input  logic clk,
   input  logic por,
   input  logic run,
   output logic done
);
   localparam int CNT_W = $clog2(CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   generate
      if (CYCLES < 2) begin : g_bad
         $error("bor_delay_timer: CYCLES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or posedge por) begin
      if (por)       cnt <= '0;
      else if (!run) cnt <= '0;
      else if (!done) cnt <= cnt + CNT_W'(1);
   end

   assign done = run && (cnt == LAST);

   // R9: a stopped timer always restarts from zero
   a_r9_timer_cleared: assert property (@(posedge clk) disable iff (por)
      (!run) |=> (cnt == '0));
endmodule

// File: rtl/bor_status.sv
module bor_status
   import bor_seq_pkg::*;
(
   input  logic              clk,
   input  logic              por,
   input  logic              wr_en,
   input  logic [STAT_W-1:0] wr_data,
   input  logic              arm_visible,
   input  logic              bor_event,
   output logic              arm_bit,
   output logic [STAT_W-1:0] stat
);
   logic por_mark, bor_mark;

   always_ff @(posedge clk or posedge por) begin
      if (por) begin
         arm_bit  <= 1'b0;
         por_mark <= 1'b0;
         bor_mark <= 1'b0;
      end else begin
         if (wr_en) begin
            arm_bit  <= wr_data[STAT_ARM];
            por_mark <= wr_data[STAT_PORM];
            bor_mark <= wr_data[STAT_BORM];
         end
         if (bor_event) bor_mark <= 1'b0;
      end
   end

   always_comb begin
      stat            = '0;
      stat[STAT_ARM]  = arm_bit && arm_visible;
      stat[STAT_PORM] = por_mark;
      stat[STAT_BORM] = bor_mark;
   end

   // R11: the power-on marker moves only on a write
   a_r11_porm_stable: assert property (@(posedge clk) disable iff (por)
      (!wr_en) |=> $stable(por_mark));
   // R10: a brown-out event always leaves the marker cleared
   a_r10_borm_cleared: assert property (@(posedge clk) disable iff (por)
      bor_event |=> !bor_mark);
endmodule

// File: rtl/brownout_seq.sv
module brownout_seq
   import bor_seq_pkg::*;
#(
   parameter int FILT_CYCLES = 16,
   parameter int PWRT_CYCLES = 64,
   parameter int SYNC_STAGES = 2,
   parameter int VSEL_W      = 2
) (
   input  logic              clk,
   input  logic              por,
   input  logic              sup_low,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_pwrt_en,
   input  logic [VSEL_W-1:0] cfg_vsel,
   input  logic              sleep,
   input  logic              wr_en,
   input  logic [2:0]        wr_data,
   output logic              rst_out,
   output logic [2:0]        stat,
   output logic [VSEL_W-1:0] vsel_out
);
   generate
      if (VSEL_W < 1) begin : g_bad_vsel
         $error("brownout_seq: VSEL_W must be at least 1");
      end
   endgenerate

   bor_mode_e  mode;
   bor_state_e state, nxt;
   logic       sup_s, armed, trip, tmr_done, arm_bit, bor_event, in_hold;

   assign mode     = bor_mode_e'(cfg_mode);
   assign vsel_out = cfg_vsel;

   bor_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .por(por), .d(sup_low), .q(sup_s));

   always_comb begin
      unique case (mode)
         MODE_OFF:     armed = 1'b0;
         MODE_SW:      armed = arm_bit;
         MODE_NOSLEEP: armed = !sleep;
         MODE_ON:      armed = 1'b1;
         default:      armed = 1'b0;
      endcase
   end

   bor_filter #(.CYCLES(FILT_CYCLES)) u_filt (
      .clk(clk), .por(por), .en(armed), .low(sup_s), .trip(trip));

   bor_delay_timer #(.CYCLES(PWRT_CYCLES)) u_tmr (
      .clk(clk), .por(por), .run(state == ST_DELAY), .done(tmr_done));

   always_comb begin
      nxt = state;
      unique case (state)
         ST_RUN:   if (trip) nxt = ST_HOLD;
         ST_HOLD:  if (!sup_s) nxt = cfg_pwrt_en ? ST_DELAY : ST_RUN;
         ST_DELAY: if (sup_s) nxt = ST_HOLD;
                   else if (tmr_done) nxt = ST_RUN;
         default:  nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or posedge por)
      if (por) state <= ST_RUN;
      else     state <= nxt;

   assign bor_event = (nxt == ST_HOLD) && (state != ST_HOLD);
   assign in_hold   = (state == ST_HOLD);
   assign rst_out   = por || (state != ST_RUN);

   bor_status u_stat (
      .clk(clk), .por(por), .wr_en(wr_en), .wr_data(wr_data),
      .arm_visible(mode == MODE_SW), .bor_event(bor_event),
      .arm_bit(arm_bit), .stat(stat));

   // R1: policy off never leaves run
   a_r1_off_no_reset: assert property (@(posedge clk) disable iff (por)
      (mode == MODE_OFF && state == ST_RUN) |=> (state == ST_RUN));
   // R3: software policy with arm bit clear never leaves run
   a_r3_sw_gated: assert property (@(posedge clk) disable iff (por)
      (mode == MODE_SW && !arm_bit && state == ST_RUN) |=> (state == ST_RUN));
   // R4: sleep gating
   a_r4_sleep_gated: assert property (@(posedge clk) disable iff (por)
      (mode == MODE_NOSLEEP && sleep && state == ST_RUN) |=> (state == ST_RUN));
   // R5: entry from run only after the filter trips
   a_r5_entry_filtered: assert property (@(posedge clk) disable iff (por)
      (in_hold && $past(state) == ST_RUN) |-> $past(trip));
   // R6: held while supply stays low
   a_r6_hold_low: assert property (@(posedge clk) disable iff (por)
      (in_hold && sup_s) |=> in_hold);
   // R7: no delay -> straight back to run
   a_r7_no_delay: assert property (@(posedge clk) disable iff (por)
      (in_hold && !sup_s && !cfg_pwrt_en) |=> (state == ST_RUN && !rst_out));
   // R8: delay holds until terminal count
   a_r8_delay_holds: assert property (@(posedge clk) disable iff (por)
      (state == ST_DELAY && !sup_s && !tmr_done) |=> (state == ST_DELAY && rst_out));
   // R9: a sag during the delay re-enters brown-out reset
   a_r9_sag_restarts: assert property (@(posedge clk) disable iff (por)
      (state == ST_DELAY && sup_s) |=> (in_hold && !stat[STAT_BORM]));
   // R10: marker clear on entry
   a_r10_entry_clears: assert property (@(posedge clk) disable iff (por)
      $rose(in_hold) |-> !stat[STAT_BORM]);
   // R12: threshold code pass-through
   a_r12_vsel: assert property (@(posedge clk) disable iff (por)
      vsel_out == cfg_vsel);
endmodule

// File: tb/sim_brownout_seq.sv
module sim_brownout_seq;
   localparam int N = 16;
   localparam int D = 64;

   logic       clk = 1'b0;
   logic       por = 1'b0;
   logic       sup_low = 1'b0;
   logic [1:0] cfg_mode = 2'b11;
   logic       cfg_pwrt_en = 1'b0;
   logic [1:0] cfg_vsel = 2'b00;
   logic       sleep = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_data = 3'b000;
   logic       rst_out;
   logic [2:0] stat;
   logic [1:0] vsel_out;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   brownout_seq #(.FILT_CYCLES(N), .PWRT_CYCLES(D), .SYNC_STAGES(2), .VSEL_W(2)) u0 (
      .clk(clk), .por(por), .sup_low(sup_low), .cfg_mode(cfg_mode),
      .cfg_pwrt_en(cfg_pwrt_en), .cfg_vsel(cfg_vsel), .sleep(sleep),
      .wr_en(wr_en), .wr_data(wr_data), .rst_out(rst_out), .stat(stat),
      .vsel_out(vsel_out));

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [2:0] v);
      wr_en = 1'b1; wr_data = v;
      tick(1);
      wr_en = 1'b0;
   endtask

   task automatic do_por();
      por = 1'b1;
      tick(2);
      chk("R13 reset held during por", rst_out, 1);
      por = 1'b0;
      tick(1);
   endtask

   task automatic t_reset();
      wr(3'b011);
      do_por();
      chk("R13 status cleared", stat, 3'b000);
      chk("R13 reset released", rst_out, 0);
   endtask

   task automatic t_vsel();
      cfg_vsel = 2'b10; #1;
      chk("R12 vsel 2", vsel_out, 2'b10);
      cfg_vsel = 2'b01; #1;
      chk("R12 vsel 1", vsel_out, 2'b01);
   endtask

   task automatic t_off();
      cfg_mode = 2'b00; cfg_pwrt_en = 1'b1;
      sup_low = 1'b1;
      tick(N + 20);
      chk("R1 off policy ignores low", rst_out, 0);
      sup_low = 1'b0;
      tick(4);
      cfg_pwrt_en = 1'b0;
   endtask

   task automatic t_on_latency();
      cfg_mode = 2'b11; cfg_pwrt_en = 1'b0;
      wr(3'b011);
      chk("R3 arm reads 0 in mode 11", stat[2], 0);
      sup_low = 1'b1;
      tick(N + 2);
      chk("R5 not yet reset", rst_out, 0);
      tick(1);
      chk("R2 R5 reset at filter end", rst_out, 1);
      chk("R10 brown-out marker cleared", stat[0], 0);
      chk("R11 power-on marker kept", stat[1], 1);
      tick(50);
      chk("R6 held while low", rst_out, 1);
      sup_low = 1'b0;
      tick(2);
      chk("R7 still held", rst_out, 1);
      tick(1);
      chk("R7 released without delay", rst_out, 0);
   endtask

   task automatic t_short_dip();
      cfg_mode = 2'b11;
      sup_low = 1'b1;
      tick(N - 1);
      sup_low = 1'b0;
      tick(N + 10);
      chk("R5 short dip ignored", rst_out, 0);
   endtask

   task automatic t_sw_gate();
      cfg_mode = 2'b01;
      wr(3'b010);
      chk("R3 arm reads 0", stat[2], 0);
      sup_low = 1'b1;
      tick(N + 20);
      chk("R3 disarmed ignores low", rst_out, 0);
      sup_low = 1'b0;
      tick(4);
      wr(3'b110);
      chk("R3 arm reads back", stat[2], 1);
      sup_low = 1'b1;
      tick(N + 3);
      chk("R3 armed resets", rst_out, 1);
      sup_low = 1'b0;
      tick(4);
      chk("R3 recovered", rst_out, 0);
      cfg_mode = 2'b10; #1;
      chk("R3 arm hidden in mode 10", stat[2], 0);
      cfg_mode = 2'b11;
      wr(3'b010);
   endtask

   task automatic t_sleep();
      cfg_mode = 2'b10; sleep = 1'b1;
      sup_low = 1'b1;
      tick(N + 20);
      chk("R4 sleep disarms", rst_out, 0);
      sleep = 1'b0;
      tick(N);
      chk("R4 filter restarts on wake", rst_out, 0);
      tick(1);
      chk("R4 reset after wake", rst_out, 1);
      sup_low = 1'b0;
      tick(4);
      chk("R4 recovered", rst_out, 0);
      cfg_mode = 2'b11;
   endtask

   task automatic t_delay();
      cfg_mode = 2'b11; cfg_pwrt_en = 1'b1;
      sup_low = 1'b1;
      tick(N + 3);
      chk("R8 tripped", rst_out, 1);
      sup_low = 1'b0;
      tick(D + 2);
      chk("R8 held through delay", rst_out, 1);
      tick(1);
      chk("R8 released after delay", rst_out, 0);
   endtask

   task automatic t_restart();
      cfg_mode = 2'b11; cfg_pwrt_en = 1'b1;
      sup_low = 1'b1;
      tick(N + 3);
      sup_low = 1'b0;
      tick(3 + D / 2);
      chk("R9 mid delay", rst_out, 1);
      sup_low = 1'b1;
      tick(3);
      sup_low = 1'b0;
      tick(D + 2);
      chk("R9 full delay reruns", rst_out, 1);
      tick(1);
      chk("R9 released after rerun", rst_out, 0);
      cfg_pwrt_en = 1'b0;
   endtask

   initial begin
      do_por();
      t_reset();
      t_vsel();
      t_off();
      t_on_latency();
      t_short_dip();
      t_sw_gate();
      t_sleep();
      t_delay();
      t_restart();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule